// File: doc/BRIEF.md
# Carry-Out Pulse-Density Modulator

This block converts an unsigned digital sample into a one-bit pulse-density stream. An external RC low-pass filter averages that stream into an analog voltage. On each cycle where the step enable is high, a wrapping accumulator adds the present sample. The carry out of that addition is registered as the output bit. A larger sample makes the accumulator wrap more often, so the density of high bits follows the sample value.

The step enable comes from a counter-and-toggle clock divider outside this block. That divider runs much faster than the rate at which the waveform samples change. The modulator uses no error feedback and no DC correction. The output bit is taken directly from the carry and nothing else adjusts it.

Top module: `pdm_out_stage`

## Requirements
- R1: While `rst_n` is low, the accumulator and `pdm_o` clear to zero. The first enabled step after reset therefore begins from an accumulator value of zero.
- R2: On each rising clock edge with `step_en` high, the accumulator becomes (accumulator + `sample`) mod 2^16, with `sample` treated as unsigned. `pdm_o` becomes 1 if that addition carried past bit 15 and 0 otherwise. The new value is visible after that edge.
- R3: While `sample` is 0, every enabled step drives `pdm_o` low.
- R4: With a constant `sample` of N, a run of 65536 consecutive enabled steps produces exactly N steps with `pdm_o` high.
- R5: On an edge with `step_en` low, both the accumulator and `pdm_o` keep their values, whatever `sample` holds.
- R6: With `sample` = 16'hFFFF, every enabled step whose starting accumulator is nonzero drives `pdm_o` high. Starting from reset, the first step is low and every later step is high.
- R7: `sample` is read only on enabled edges. A new sample takes effect on the first enabled step after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Modulator step strobe from the divider |
| sample | input | 16 | Unsigned sample to be modulated |
| pdm_o | output | 1 | Registered pulse-density output bit |

## Verification
The bench drives the two sample extremes. A zero sample must never raise the output. A full-scale sample must give one low step after reset and then stay high. A design that compared with the wrong sign, or that did not clear the accumulator, would show a spurious pulse or one high step too many. A full 65536-step run counts the high bits. That count exposes an accumulator that is one bit short or that saturates instead of wrapping, because either error changes the number of highs. Stalled edges carry a changing sample, so a design that updates its state without the enable leaves the accumulator at a different value when stepping resumes.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
    localparam int unsigned PDM_SAMPLE_W = 16;
endpackage

// File: rtl/pdm_carry_add.sv
module pdm_carry_add #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    localparam int unsigned WIDE = W + 1;

    logic [WIDE-1:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i};
        sum_o    = wide_sum[W-1:0];
        carry_o  = wide_sum[W];
    end
endmodule

// File: rtl/pdm_out_stage.sv
module pdm_out_stage
    import pdm_pkg::*;
#(
    parameter int unsigned W = PDM_SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic [W-1:0] sample,
    output logic         pdm_o
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         pdm;
    } mod_state_t;

    mod_state_t state_d, state_q;

    logic [W-1:0] add_sum;
    logic         add_carry;

    pdm_carry_add #(.W(W)) u_add (
        .a_i     (state_q.acc),
        .b_i     (sample),
        .sum_o   (add_sum),
        .carry_o (add_carry)
    );

    always_comb begin
        state_d = state_q;
        if (step_en) begin
            state_d.acc = add_sum;
            state_d.pdm = add_carry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pdm_o = state_q.pdm;
endmodule

// File: rtl/pdm_out_stage_chk.sv
module pdm_out_stage_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_en,
    input logic [W-1:0] sample,
    input logic [W-1:0] acc,
    input logic         pdm_o
);
    logic [W:0] ref_sum;
    assign ref_sum = {1'b0, acc} + {1'b0, sample};

    assert_carry_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (pdm_o == $past(ref_sum[W])));

    assert_acc_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (acc == $past(ref_sum[W-1:0])));

    assert_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && sample == '0) |=> !pdm_o);

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(pdm_o) && $stable(acc)));

    assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && (&sample) && acc != '0) |=> pdm_o);
endmodule

bind pdm_out_stage pdm_out_stage_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .sample  (sample),
    .acc     (state_q.acc),
    .pdm_o   (pdm_o)
);

// File: tb/tb_pdm_out_stage.sv
module tb_pdm_out_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [15:0] sample = '0;
    logic        pdm_o;

    int checks = 0;
    int fails = 0;
    logic [15:0] m_acc = '0;

    always #2 clk = ~clk;

    pdm_out_stage dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .sample(sample), .pdm_o(pdm_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pdm_o=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; step_en = 1'b0; sample = '0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_acc = '0;
    endtask

    // one clock with the given inputs; returns the output after that edge
    task automatic tick(input logic en, input logic [15:0] s, output logic o);
        step_en = en; sample = s;
        @(posedge clk); @(negedge clk);
        o = pdm_o;
    endtask

    task automatic model_step(input string req, input logic [15:0] s);
        logic [16:0] w;
        logic o;
        w = {1'b0, m_acc} + {1'b0, s};
        m_acc = w[15:0];
        tick(1'b1, s, o);
        check(req, o, w[16]);
    endtask

    task automatic t_reset();
        logic o;
        do_reset();
        check("R1", pdm_o, 1'b0);
        tick(1'b1, 16'h8000, o); check("R1", o, 1'b0);
        tick(1'b1, 16'h8000, o); check("R1", o, 1'b1);
    endtask

    task automatic t_zero();
        logic o;
        do_reset();
        for (int i = 0; i < 20; i++) begin
            tick(1'b1, 16'h0000, o); check("R3", o, 1'b0);
        end
    endtask

    task automatic t_full();
        logic o;
        do_reset();
        tick(1'b1, 16'hFFFF, o); check("R6", o, 1'b0);
        for (int i = 0; i < 10; i++) begin
            tick(1'b1, 16'hFFFF, o); check("R6", o, 1'b1);
        end
    endtask

    task automatic t_hold();
        logic o;
        do_reset();
        tick(1'b1, 16'hC000, o); check("R5", o, 1'b0);
        tick(1'b1, 16'hC000, o); check("R5", o, 1'b1);
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 16'hFFFF - 16'(i), o); check("R5", o, 1'b1);
        end
        // accumulator held at 0x8000: +0x4000 gives 0xC000, no carry
        tick(1'b1, 16'h4000, o); check("R5", o, 1'b0);
        // new sample used on the next enabled step: 0xC000+0x4000 wraps
        tick(1'b1, 16'h4000, o); check("R7", o, 1'b1);
        tick(1'b0, 16'hFFFF, o); check("R7", o, 1'b1);
        tick(1'b1, 16'h0001, o); check("R7", o, 1'b0);
    endtask

    task automatic t_model();
        do_reset();
        model_step("R2", 16'h1234);
        model_step("R2", 16'hF00D);
        model_step("R2", 16'h7FFF);
        model_step("R2", 16'h8001);
        model_step("R2", 16'h0000);
        for (int i = 0; i < 40; i++) begin
            model_step("R2", 16'((i * 16'h2F1B) ^ 16'h5A5A));
        end
    endtask

    task automatic t_density();
        int highs = 0;
        do_reset();
        step_en = 1'b1; sample = 16'd40000;
        for (int i = 0; i < 65536; i++) begin
            @(posedge clk); @(negedge clk);
            if (pdm_o) highs++;
        end
        step_en = 1'b0;
        checks++;
        if (highs != 40000) begin
            fails++;
            $display("FAIL R4: high count=%0d expected %0d", highs, 40000);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_zero();
        t_full();
        t_hold();
        t_model();
        t_density();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule